// File: doc/BRIEF.md
# BMC-to-Host Interrupt Controller

This block owns the host-visible interrupt mask register of a block-transfer style management interface and drives one level-sensitive interrupt line toward the host. The register has two fields: an enable bit and a pending bit. The host writes the register to turn the interrupt on or off and to acknowledge it. The management-controller side reports two kinds of event: a response has become ready, and the SMS attention flag has risen or fallen. A global interrupt enable and an "interrupt wired" configuration bit gate the events. A reset request input with a cold/warm qualifier clears the register on a cold reset only.

Internally the register is held as a three-state machine. `ST_OFF` means disabled with nothing pending. `ST_ARMED` means enabled and not pending. `ST_FIRED` means enabled and pending. The state code is the register value itself, so the readback port shows the state directly. The transitions are as follows.
- Enable write: `ST_OFF` goes to `ST_ARMED`, or to `ST_FIRED` if either attention flag is already high.
- Disable write: `ST_ARMED` or `ST_FIRED` goes to `ST_OFF`.
- Acknowledge (write-one-to-clear): `ST_FIRED` goes to `ST_ARMED`.
- Response fire or SMS fire: `ST_ARMED` goes to `ST_FIRED`.
- SMS drop: `ST_FIRED` goes to `ST_ARMED`.
- Cold reset: any state goes to `ST_OFF`.

Within one cycle the host write is applied first. The events are then applied to the result of the write, and a cold reset overrides both. The interrupt line is a separate flop that is loaded in the same cycle as the state.

Top module: `bmcirq_top`

## Requirements
- R1: Readback `mask_rdata` bit 0 is the enable and bit 1 is the pending flag. After `rst_n` is asserted both read 0 and `irq_o` is low.
- R2: A host write with bit 0 = 1 while the enable is 0 sets the enable. In the same cycle it sets pending if `b2h_atn` or `sms_atn` is high; otherwise pending stays clear.
- R3: A host write with bit 0 = 0 clears both the enable and pending.
- R4: A host write with bit 1 = 1 clears pending if pending is set. It has no effect when pending is clear. A write with bit 1 = 0 never clears pending. Rewriting bit 0 = 1 while already enabled never sets pending.
- R5: A `rsp_ready` pulse sets pending only if `irq_present`, `irq_glb_en` and the enable are all 1. Otherwise it changes nothing, and it changes nothing when pending is already set.
- R6: A `sms_rise` pulse sets pending only if `sms_rise_irq` is 1, `b2h_atn` is 0, and `irq_present`, `irq_glb_en` and the enable are all 1.
- R7: A `sms_fall` pulse clears pending only while `b2h_atn` is 0.
- R8: `rst_req` with `rst_cold` = 1 clears both the enable and pending. With `rst_cold` = 0 it leaves both unchanged.
- R9: `irq_o` is high exactly when the readback pending bit is 1. Both change on the same clock edge, one cycle after the causing input.
- R10: Within one cycle a cold reset overrides every write and event. A host write is applied before the events. An enabling write of 2'b11 with attention high therefore ends enabled and not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | 2 | Host write data: bit 0 enable, bit 1 write-one-to-clear pending |
| b2h_atn | input | 1 | Current BMC-to-host attention flag |
| sms_atn | input | 1 | Current SMS attention flag |
| rsp_ready | input | 1 | One-cycle pulse: a response is ready for the host |
| sms_rise | input | 1 | One-cycle pulse: SMS attention went 0 to 1 |
| sms_rise_irq | input | 1 | Interrupt request flag qualifying `sms_rise` |
| sms_fall | input | 1 | One-cycle pulse: SMS attention went 1 to 0 |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_present | input | 1 | Configuration: an interrupt line is wired |
| rst_req | input | 1 | Interface reset request pulse |
| rst_cold | input | 1 | Qualifies `rst_req` as cold (1) or warm (0) |
| mask_rdata | output | 2 | Mask register readback {pending, enable} |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The hardest situations to reach are the same-cycle collisions. The cases are: a cold reset arriving with an enabling write, an enabling acknowledge write while attention is high, and a disable or enable write landing together with a response event. Each of these hinges on the order in which the write and the events are applied. The stimulus table first walks the machine into the required starting state (`ST_OFF`, `ST_ARMED` or `ST_FIRED`). It then drives these combinations in a single cycle and checks the register and the line one edge later. The gating cases are driven from `ST_ARMED`. These are a response blocked by the wired bit or by the global enable, and an SMS rise blocked by a high BMC-to-host attention flag or by a missing request flag. Driving them from `ST_ARMED` means that a wrongly fired interrupt shows up at the pins.

// File: rtl/bmcirq_pkg.sv
package bmcirq_pkg;

    localparam int unsigned MASK_W   = 2;
    localparam int unsigned EN_POS   = 0;
    localparam int unsigned PEND_POS = 1;

    // state code equals the register image {pending, enable}
    typedef enum logic [MASK_W-1:0] {
        ST_OFF   = 2'b00,
        ST_ARMED = 2'b01,
        ST_FIRED = 2'b11
    } irq_state_e;

    typedef struct packed {
        logic valid;   // host wrote the mask register
        logic en;      // written enable value
        logic ack;     // write-one-to-clear of pending
    } host_cmd_t;

    typedef struct packed {
        logic cold;      // cold reset this cycle
        logic atn_any;   // either attention flag high
        logic rsp_fire;  // response event passes the gates
        logic sms_fire;  // SMS rise passes the gates
        logic sms_drop;  // SMS fall allowed to clear pending
    } evt_qual_t;

endpackage

// File: rtl/bmcirq_host_wr.sv
module bmcirq_host_wr
    import bmcirq_pkg::*;
#(
    parameter int unsigned W   = MASK_W,
    parameter int unsigned ENB = EN_POS,
    parameter int unsigned PDB = PEND_POS
) (
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output host_cmd_t    cmd
);
    always_comb begin
        cmd.valid = wr;
        cmd.en    = wr & wdata[ENB];
        cmd.ack   = wr & wdata[PDB];
    end
endmodule

// File: rtl/bmcirq_evt_qual.sv
module bmcirq_evt_qual
    import bmcirq_pkg::*;
(
    input  logic      b2h_atn,
    input  logic      sms_atn,
    input  logic      rsp_ready,
    input  logic      sms_rise,
    input  logic      sms_rise_irq,
    input  logic      sms_fall,
    input  logic      irq_glb_en,
    input  logic      irq_present,
    input  logic      rst_req,
    input  logic      rst_cold,
    output evt_qual_t q
);
    logic gates_open;

    always_comb begin
        gates_open = irq_present & irq_glb_en;
        q.cold     = rst_req & rst_cold;
        q.atn_any  = b2h_atn | sms_atn;
        q.rsp_fire = rsp_ready & gates_open;
        q.sms_fire = sms_rise & sms_rise_irq & gates_open & ~b2h_atn;
        q.sms_drop = sms_fall & ~b2h_atn;
    end
endmodule

// File: rtl/bmcirq_fsm.sv
module bmcirq_fsm
    import bmcirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  host_cmd_t  cmd,
    input  evt_qual_t  ev,
    output irq_state_e state,
    output logic       irq_o
);
    irq_state_e st_q, st_wr, st_ev, st_nxt;
    logic       irq_q;

    // stage 1: host write
    always_comb begin
        st_wr = st_q;
        if (cmd.valid) begin
            unique case (st_q)
                ST_OFF:            if (cmd.en)  st_wr = ev.atn_any ? ST_FIRED : ST_ARMED;
                ST_ARMED, ST_FIRED: if (!cmd.en) st_wr = ST_OFF;
                default:           st_wr = ST_OFF;
            endcase
            if (cmd.ack && st_wr == ST_FIRED) st_wr = ST_ARMED;
        end
    end

    // stage 2: BMC-side events on the post-write state, then cold reset
    always_comb begin
        st_ev = st_wr;
        unique case (st_wr)
            ST_OFF:   st_ev = ST_OFF;
            ST_ARMED: if (ev.rsp_fire || ev.sms_fire) st_ev = ST_FIRED;
            ST_FIRED: if (ev.sms_drop) st_ev = ST_ARMED;
            default:  st_ev = ST_OFF;
        endcase
        st_nxt = ev.cold ? ST_OFF : st_ev;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (st_nxt == ST_FIRED);
    end

    assign state = st_q;
    assign irq_o = irq_q;

    assert_line_tracks_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == st_q[PEND_POS]);

    assert_pending_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[PEND_POS] |-> st_q[EN_POS]);

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.valid && !cmd.en) |=> st_q == ST_OFF);

    assert_rsp_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && ev.rsp_fire && !cmd.valid && !ev.cold) |=> st_q == ST_FIRED);

    assert_sms_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRED && ev.sms_drop && !cmd.valid && !ev.cold) |=> st_q == ST_ARMED);

    assert_cold_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev.cold |=> (st_q == ST_OFF && !irq_q));
endmodule

// File: rtl/bmcirq_top.sv
module bmcirq_top
    import bmcirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              b2h_atn,
    input  logic              sms_atn,
    input  logic              rsp_ready,
    input  logic              sms_rise,
    input  logic              sms_rise_irq,
    input  logic              sms_fall,
    input  logic              irq_glb_en,
    input  logic              irq_present,
    input  logic              rst_req,
    input  logic              rst_cold,
    output logic [MASK_W-1:0] mask_rdata,
    output logic              irq_o
);
    host_cmd_t  cmd;
    evt_qual_t  ev;
    irq_state_e state;

    bmcirq_host_wr u_wr (
        .wr    (mask_wr),
        .wdata (mask_wdata),
        .cmd   (cmd)
    );

    bmcirq_evt_qual u_qual (
        .b2h_atn      (b2h_atn),
        .sms_atn      (sms_atn),
        .rsp_ready    (rsp_ready),
        .sms_rise     (sms_rise),
        .sms_rise_irq (sms_rise_irq),
        .sms_fall     (sms_fall),
        .irq_glb_en   (irq_glb_en),
        .irq_present  (irq_present),
        .rst_req      (rst_req),
        .rst_cold     (rst_cold),
        .q            (ev)
    );

    bmcirq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ev    (ev),
        .state (state),
        .irq_o (irq_o)
    );

    always_comb begin
        mask_rdata           = '0;
        mask_rdata[EN_POS]   = (state != ST_OFF);
        mask_rdata[PEND_POS] = (state == ST_FIRED);
    end
endmodule

// File: tb/bmcirq_top_tb.sv
module bmcirq_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_wr = 1'b0;
    logic [1:0] mask_wdata = 2'b00;
    logic       b2h_atn = 1'b0, sms_atn = 1'b0;
    logic       rsp_ready = 1'b0, sms_rise = 1'b0, sms_rise_irq = 1'b0, sms_fall = 1'b0;
    logic       irq_glb_en = 1'b1, irq_present = 1'b1;
    logic       rst_req = 1'b0, rst_cold = 1'b0;
    logic [1:0] mask_rdata;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bmcirq_top u_dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .b2h_atn(b2h_atn), .sms_atn(sms_atn), .rsp_ready(rsp_ready),
        .sms_rise(sms_rise), .sms_rise_irq(sms_rise_irq), .sms_fall(sms_fall),
        .irq_glb_en(irq_glb_en), .irq_present(irq_present),
        .rst_req(rst_req), .rst_cold(rst_cold),
        .mask_rdata(mask_rdata), .irq_o(irq_o)
    );

    // fields: wr wd[2] b2h sms rsp srise sirq sfall glb pres rreq rcold exp[2] req[4]
    localparam int NV = 28;
    localparam logic [18:0] VEC [NV] = '{
        19'b0_00_00_0_00_0_11_00_00_0001, // R1 idle
        19'b0_00_00_1_00_0_11_00_00_0101, // R5 rsp while off
        19'b1_01_00_0_00_0_11_00_01_0010, // R2 enable, no attention
        19'b0_00_00_1_00_0_11_00_11_0101, // R5 rsp fires
        19'b0_00_00_1_00_0_11_00_11_0101, // R5 rsp while pending
        19'b1_11_00_0_00_0_11_00_01_0100, // R4 ack
        19'b1_01_10_0_00_0_11_00_01_0100, // R4 re-enable no refire
        19'b1_00_00_0_00_0_11_00_00_0011, // R3 disable
        19'b1_01_10_0_00_0_11_00_11_0010, // R2 enable with b2h attention
        19'b1_01_00_0_00_0_11_00_11_0100, // R4 bit1=0 keeps pending
        19'b1_00_00_0_00_0_11_00_00_0011, // R3 disable clears pending
        19'b1_01_01_0_00_0_11_00_11_0010, // R2 enable with sms attention
        19'b0_00_11_0_00_1_11_00_11_0111, // R7 fall blocked by b2h
        19'b0_00_00_0_00_1_11_00_01_0111, // R7 fall clears
        19'b0_00_10_0_11_0_11_00_01_0110, // R6 rise blocked by b2h
        19'b0_00_00_0_10_0_11_00_01_0110, // R6 rise without request flag
        19'b0_00_00_0_11_0_01_00_01_0110, // R6 rise with global enable off
        19'b0_00_00_1_00_0_10_00_01_0101, // R5 rsp not wired
        19'b0_00_00_1_00_0_01_00_01_0101, // R5 rsp global off
        19'b0_00_01_0_11_0_11_00_11_0110, // R6 rise fires
        19'b0_00_00_0_00_0_11_10_11_1000, // R8 warm reset no effect
        19'b0_00_00_0_00_0_11_11_00_1000, // R8 cold reset clears
        19'b1_01_10_0_00_0_11_11_00_1010, // R10 cold beats write
        19'b1_11_10_0_00_0_11_00_01_1010, // R10 enable+ack with attention
        19'b1_00_00_1_00_0_11_00_00_1010, // R10 disable then rsp
        19'b1_01_00_1_00_0_11_00_11_1010, // R10 enable then rsp
        19'b1_10_00_0_00_0_11_00_00_0011, // R3 disable from fired
        19'b1_10_00_0_00_0_11_00_00_0100  // R4 ack with nothing pending
    };

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mask_wr = 0; mask_wdata = 0; b2h_atn = 0; sms_atn = 0; rsp_ready = 0;
        sms_rise = 0; sms_rise_irq = 0; sms_fall = 0; irq_glb_en = 1; irq_present = 1;
        rst_req = 0; rst_cold = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mask after reset", mask_rdata, 2'b00);
        check("R1 irq after reset", {1'b0, irq_o}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mask after release", mask_rdata, 2'b00);

        for (int i = 0; i < NV; i++) begin
            mask_wr      = VEC[i][18];
            mask_wdata   = VEC[i][17:16];
            b2h_atn      = VEC[i][15];
            sms_atn      = VEC[i][14];
            rsp_ready    = VEC[i][13];
            sms_rise     = VEC[i][12];
            sms_rise_irq = VEC[i][11];
            sms_fall     = VEC[i][10];
            irq_glb_en   = VEC[i][9];
            irq_present  = VEC[i][8];
            rst_req      = VEC[i][7];
            rst_cold     = VEC[i][6];
            @(negedge clk);
            check($sformatf("R%0d vec %0d mask", VEC[i][3:0], i), mask_rdata, VEC[i][5:4]);
            check($sformatf("R9 vec %0d irq", i), {1'b0, irq_o}, {1'b0, VEC[i][5]});
        end
        idle_inputs();

        // R1: asynchronous reset from the fired state
        mask_wr = 1; mask_wdata = 2'b01; b2h_atn = 1;
        @(negedge clk);
        idle_inputs();
        check("R2 fired before reset", mask_rdata, 2'b11);
        rst_n = 1'b0;
        #3;
        check("R1 async reset mask", mask_rdata, 2'b00);
        check("R1 async reset irq", {1'b0, irq_o}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: line stays low while enabled but idle
        mask_wr = 1; mask_wdata = 2'b01;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        check("R9 armed irq low", {1'b0, irq_o}, 2'b00);
        check("R2 armed mask", mask_rdata, 2'b01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule